// File: doc/BRIEF.md
# I2C Slave Receiver with Status Codes

This block is a slave-only I2C engine that sits behind a small host register port. Once enabled, it watches the two bus wires for a START condition and shifts in the address byte that follows. It then compares that byte with its programmed 7-bit address and, if software has turned the option on, with the general call address. When the address matches and the acknowledge-enable bit is set, it pulls SDA low for the acknowledge clock, sets its interrupt flag and posts a one-byte status code that tells software what happened.

While the flag is set the block holds SCL low, so the master waits. Software reads the status code, reads the data register where needed, and clears the flag so the next byte can come in. Whether each data byte gets an ACK or a NACK follows the acknowledge-enable bit at the moment the byte completes. The status code shows which of the two was sent.

A STOP or a repeated START that arrives while the block is addressed as a receiver produces its own status code, and the block then leaves the addressed state. A read-direction match is reported with its own code. The slave then leaves SDA released, so it sends no data.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, irq is 0, scl_oe and sda_oe are 0, the control register at offset 0 reads 0x00 and the status register at offset 3 reads 0xF8. Register map: offset 0 is control (bit0 enable, bit1 acknowledge-enable, bit2 interrupt flag); offset 1 is the last received data byte; offset 2 is the own address (bits 6:0 address, bit7 general call enable); offset 3 is status (read only).
- R2: With enable (control bit0) at 0, a START followed by the block's own address draws no ACK and leaves irq at 0.
- R3: With enable and acknowledge-enable set, a write-direction address byte equal to the own address is ACKed on the ninth clock, irq goes to 1 and status reads 0x60.
- R4: An address byte that matches neither the own address nor an enabled general call, or any address while acknowledge-enable is 0, is NACKed and raises no irq. The block then ignores the bus until the next START or STOP.
- R5: Address 0x00 with the write direction is ACKed with status 0x70 only when own-address bit7 is 1. It is NACKed when bit7 is 0, and a read-direction general call is always NACKed.
- R6: While irq is 1 after an acknowledge clock, scl_oe is 1. Writing control with bit2 = 1 leaves irq and scl_oe at 1. Writing control with bit2 = 0 clears irq and releases scl_oe.
- R7: When addressed as a receiver with acknowledge-enable at 1, each data byte is ACKed, is readable at offset 1, and gives status 0x80.
- R8: With acknowledge-enable at 0, a data byte is NACKed, still stored at offset 1, and gives status 0x88. After the flag is cleared, further bytes are ignored and raise no irq.
- R9: A STOP while addressed as a receiver sets irq with status 0xA0 without holding SCL. The block then is not addressed: a later STOP raises no irq.
- R10: A repeated START while addressed as a receiver sets irq with status 0xA0. The address byte that follows is decoded afresh.
- R11: A read-direction match of the own address is ACKed with status 0xA8. After the flag is cleared, the slave leaves SDA released, so the master reads 0xFF, and no further irq occurs.
- R12: Clearing the flag sets the status register to 0xF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |

## Verification
The bench offers every one of the 128 seven-bit addresses in write direction and expects exactly one ACK. A comparator that is off by a bit, or that checks the direction bit as part of the address, would acknowledge a neighbour or miss its own address. The general call is tried with its enable on and off and in read direction, which catches a design that answers address zero unconditionally. The ACK-to-NACK switch in the middle of a stream checks that a NACKed byte still lands in the data register and that later bytes are ignored; a design that stays addressed would raise a stray flag. A STOP and a repeated START are placed right after a byte, where a design that mixes up the two edge conditions, or that stretches SCL on the 0xA0 event, would hang the master or report the wrong code.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // register offsets on the host port
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_DATA = 2'd1;
  localparam logic [1:0] OFF_OWN  = 2'd2;
  localparam logic [1:0] OFF_STAT = 2'd3;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_AACK = 1;
  localparam int CB_FLAG = 2;

  // status codes
  localparam logic [7:0] SC_NONE   = 8'hF8;
  localparam logic [7:0] SC_ADR_W  = 8'h60;
  localparam logic [7:0] SC_GCALL  = 8'h70;
  localparam logic [7:0] SC_DAT_A  = 8'h80;
  localparam logic [7:0] SC_DAT_N  = 8'h88;
  localparam logic [7:0] SC_END    = 8'hA0;
  localparam logic [7:0] SC_ADR_R  = 8'hA8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } eng_state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA edges only count as conditions while SCL stays high on both samples
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          aack,
  input  logic          gc_en,
  input  logic [DW-2:0] own_addr,
  input  logic          flag,
  input  logic          flag_clr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          set_flag,
  output logic          rx_load,
  output logic [DW-1:0] rx_byte,
  output logic [7:0]    status,
  output logic          sda_oe,
  output logic          scl_oe
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);

  eng_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [7:0]     stat_q, stat_d;
  logic [7:0]     pend_q, pend_d;
  logic           drv_q, drv_d;
  logic           isdat_q, isdat_d;
  logic           cont_q, cont_d;

  logic           own_hit, gc_hit, rd_bit, addressed;

  assign rd_bit    = sh_q[0];
  assign own_hit   = (sh_q[DW-1:1] == own_addr);
  assign gc_hit    = gc_en & (sh_q[DW-1:1] == '0) & ~rd_bit;
  assign addressed = (st_q == ST_DATA) | ((st_q == ST_ACK) & isdat_q) | (st_q == ST_HOLD);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    stat_d   = stat_q;
    pend_d   = pend_q;
    drv_d    = drv_q;
    isdat_d  = isdat_q;
    cont_d   = cont_q;
    set_flag = 1'b0;
    rx_load  = 1'b0;

    if (flag_clr) stat_d = SC_NONE;

    if (!en) begin
      st_d = ST_IDLE;
    end else if (start_det) begin
      if (addressed) begin
        set_flag = 1'b1;
        stat_d   = SC_END;
      end
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else if (stop_det) begin
      if (addressed) begin
        set_flag = 1'b1;
        stat_d   = SC_END;
      end
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + CW'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (st_q == ST_ADDR) begin
              if ((own_hit || gc_hit) && aack) begin
                st_d    = ST_ACK;
                drv_d   = 1'b1;
                isdat_d = 1'b0;
                cont_d  = ~rd_bit;
                pend_d  = own_hit ? (rd_bit ? SC_ADR_R : SC_ADR_W) : SC_GCALL;
              end else begin
                st_d = ST_SKIP;
              end
            end else begin
              st_d    = ST_ACK;
              drv_d   = aack;
              isdat_d = 1'b1;
              cont_d  = aack;
              pend_d  = aack ? SC_DAT_A : SC_DAT_N;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_d     = ST_HOLD;
            set_flag = 1'b1;
            stat_d   = pend_q;
            rx_load  = isdat_q;
          end
        end
        ST_HOLD: begin
          if (!flag) begin
            st_d  = cont_q ? ST_DATA : ST_SKIP;
            cnt_d = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      stat_q  <= SC_NONE;
      pend_q  <= SC_NONE;
      drv_q   <= 1'b0;
      isdat_q <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      stat_q  <= stat_d;
      pend_q  <= pend_d;
      drv_q   <= drv_d;
      isdat_q <= isdat_d;
      cont_q  <= cont_d;
    end
  end

  assign rx_byte = sh_q;
  assign status  = stat_q;
  assign sda_oe  = (st_q == ST_ACK) & drv_q;
  assign scl_oe  = (st_q == ST_HOLD) & flag;

endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int AW = DW - 1;

  logic          rst_s;
  logic [1:0]    bus_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          set_flag, rx_load, flag_clr, wr_ctrl, wr_own;
  logic [DW-1:0] rx_byte;
  logic [7:0]    stat_w;

  logic          ctrl_en_q, ctrl_en_d;
  logic          ctrl_aa_q, ctrl_aa_d;
  logic          flag_q, flag_d;
  logic [AW-1:0] own_q, own_d;
  logic          gc_q, gc_d;
  logic [DW-1:0] data_q, data_d;

  // reset: asserted asynchronously, released through two flops
  i2cs_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s)
  );

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d     ({scl_i, sda_i}),
    .q     (bus_s)
  );

  i2cs_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine #(.DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_s),
    .en        (ctrl_en_q),
    .aack      (ctrl_aa_q),
    .gc_en     (gc_q),
    .own_addr  (own_q),
    .flag      (flag_q),
    .flag_clr  (flag_clr),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .set_flag  (set_flag),
    .rx_load   (rx_load),
    .rx_byte   (rx_byte),
    .status    (stat_w),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe)
  );

  assign wr_ctrl  = reg_we & (reg_addr == OFF_CTRL);
  assign wr_own   = reg_we & (reg_addr == OFF_OWN);
  assign flag_clr = wr_ctrl & ~reg_wdata[CB_FLAG] & flag_q;

  always_comb begin
    ctrl_en_d = wr_ctrl ? reg_wdata[CB_EN]   : ctrl_en_q;
    ctrl_aa_d = wr_ctrl ? reg_wdata[CB_AACK] : ctrl_aa_q;
    own_d     = wr_own  ? reg_wdata[AW-1:0]  : own_q;
    gc_d      = wr_own  ? reg_wdata[7]       : gc_q;
    data_d    = rx_load ? rx_byte            : data_q;
    // a new event wins over a clear in the same cycle; writing 1 never sets
    if (set_flag)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_en_q <= 1'b0;
      ctrl_aa_q <= 1'b0;
      flag_q    <= 1'b0;
      own_q     <= '0;
      gc_q      <= 1'b0;
      data_q    <= '0;
    end else begin
      ctrl_en_q <= ctrl_en_d;
      ctrl_aa_q <= ctrl_aa_d;
      flag_q    <= flag_d;
      own_q     <= own_d;
      gc_q      <= gc_d;
      data_q    <= data_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFF_CTRL: reg_rdata = {5'b0, flag_q, ctrl_aa_q, ctrl_en_q};
      OFF_DATA: reg_rdata = 8'(data_q);
      OFF_OWN:  reg_rdata = {gc_q, 7'(own_q)};
      default:  reg_rdata = stat_w;
    endcase
  end

  assign irq = flag_q;

endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       en,
  input logic [7:0] status
);

  // R6: SCL is only stretched while the interrupt flag is pending
  assert_stretch_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> irq);

  // R6: SDA is released whenever SCL is being held
  assert_no_dual_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_oe && sda_oe));

  // R2: a disabled block releases both wires on the next cycle
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R3, R5, R7, R8, R9, R11: a rising flag carries a defined event code
  assert_code_on_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status == 8'h60 || status == 8'h70 || status == 8'h80 ||
                    status == 8'h88 || status == 8'hA0 || status == 8'hA8));

  // R12: a cleared flag leaves the idle code behind
  assert_idle_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status == 8'hF8));

endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq),
  .scl_oe (scl_oe),
  .sda_oe (sda_oe),
  .en     (ctrl_en_q),
  .status (stat_w)
);

// File: tb/test_i2cs_slave.sv
`timescale 1ns/1ps
module test_i2cs_slave;

  localparam int H   = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       scl_oe, sda_oe;
  logic       scl_m, sda_m;
  logic       scl_w, sda_w;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  assign scl_w = scl_m & ~scl_oe;
  assign sda_w = sda_m & ~sda_oe;

  i2cs_slave i_i2cs_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .scl_i     (scl_w),
    .sda_i     (sda_w),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw();
    scl_m = 1'b1; hw();
    sda_m = 1'b0; hw();
    scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw();
    scl_m = 1'b1; hw();
    sda_m = 1'b1; hw();
  endtask

  task automatic bus_bit(input logic b, output logic got);
    sda_m = b; hw();
    scl_m = 1'b1;
    wait (scl_w === 1'b1);
    hw();
    got = sda_w;
    scl_m = 1'b0; hw();
  endtask

  // returns the byte seen on the wire and whether the slave pulled ACK
  task automatic xfer(input logic [7:0] b, output logic ack, output logic [7:0] seen);
    logic a9;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], seen[i]);
    bus_bit(1'b1, a9);
    sda_m = 1'b0;
    ack = ~a9;
  endtask

  task automatic expect_event(input string tag, input logic [7:0] code);
    logic [7:0] v;
    chk(tag, irq, 1'b1);
    rd(2'd3, v);
    chk(tag, v, code);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic       ack;
    logic [7:0] seen, v;
    logic [7:0] byte_v;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 scl_oe", scl_oe, 1'b0);
    chk("R1 sda_oe", sda_oe, 1'b0);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd3, v); chk("R1 status", v, 8'hF8);

    // R2 disabled block ignores its own address
    wr(2'd2, {1'b0, OWN});
    bus_start();
    xfer({OWN, 1'b0}, ack, seen);
    bus_stop();
    chk("R2 ack", ack, 1'b0);
    chk("R2 irq", irq, 1'b0);

    // enable with acknowledge
    wr(2'd0, 8'h03);

    // R3/R4 sweep of every write address
    for (int a = 0; a < 128; a++) begin
      bus_start();
      xfer({7'(a), 1'b0}, ack, seen);
      if (7'(a) == OWN) begin
        chk("R3 own ack", ack, 1'b1);
        expect_event("R3 own status", 8'h60);
        chk("R6 hold", scl_oe, 1'b1);
        wr(2'd0, 8'h03);
        rd(2'd3, v); chk("R12 idle code", v, 8'hF8);
        bus_stop();
        expect_event("R9 stop code", 8'hA0);
        chk("R9 no stretch", scl_oe, 1'b0);
        wr(2'd0, 8'h03);
        bus_stop();
        chk("R9 not addressed", irq, 1'b0);
      end else begin
        chk("R4 foreign nack", ack, 1'b0);
        chk("R4 foreign irq", irq, 1'b0);
        bus_stop();
      end
    end

    // R4 own address while acknowledge-enable is 0
    wr(2'd0, 8'h01);
    bus_start();
    xfer({OWN, 1'b0}, ack, seen);
    chk("R4 aa off nack", ack, 1'b0);
    xfer(8'h77, ack, seen);
    chk("R4 ignored byte", irq, 1'b0);
    bus_stop();
    wr(2'd0, 8'h03);

    // R5 general call
    bus_start();
    xfer(8'h00, ack, seen);
    bus_stop();
    chk("R5 gc disabled", ack, 1'b0);
    wr(2'd2, {1'b1, OWN});
    bus_start();
    xfer(8'h01, ack, seen);
    bus_stop();
    chk("R5 gc read nack", ack, 1'b0);
    chk("R5 gc read irq", irq, 1'b0);
    bus_start();
    xfer(8'h00, ack, seen);
    chk("R5 gc ack", ack, 1'b1);
    expect_event("R5 gc status", 8'h70);
    wr(2'd0, 8'h03);
    bus_stop();
    wr(2'd0, 8'h03);
    wr(2'd2, {1'b0, OWN});

    // R6/R7 data stream with ACK
    bus_start();
    xfer({OWN, 1'b0}, ack, seen);
    chk("R6 flag", irq, 1'b1);
    wr(2'd0, 8'h07);
    chk("R6 write one keeps flag", irq, 1'b1);
    chk("R6 write one keeps hold", scl_oe, 1'b1);
    wr(2'd0, 8'h03);
    chk("R6 cleared flag", irq, 1'b0);
    chk("R6 released", scl_oe, 1'b0);
    for (int k = 0; k < 16; k++) begin
      byte_v = 8'((k * 37 + 5) ^ (k << 4));
      xfer(byte_v, ack, seen);
      chk("R7 ack", ack, 1'b1);
      expect_event("R7 status", 8'h80);
      rd(2'd1, v); chk("R7 data", v, byte_v);
      wr(2'd0, 8'h03);
    end

    // R8 switch to NACK mid stream
    xfer(8'hC3, ack, seen);
    expect_event("R8 prior ack", 8'h80);
    wr(2'd0, 8'h05);
    chk("R8 flag kept", irq, 1'b1);
    wr(2'd0, 8'h01);
    xfer(8'h96, ack, seen);
    chk("R8 nack", ack, 1'b0);
    expect_event("R8 status", 8'h88);
    rd(2'd1, v); chk("R8 data stored", v, 8'h96);
    wr(2'd0, 8'h01);
    xfer(8'h11, ack, seen);
    chk("R8 ignored irq", irq, 1'b0);
    bus_stop();
    chk("R8 stop not addressed", irq, 1'b0);
    wr(2'd0, 8'h03);

    // R10 repeated start while addressed
    bus_start();
    xfer({OWN, 1'b0}, ack, seen);
    wr(2'd0, 8'h03);
    xfer(8'h3C, ack, seen);
    expect_event("R10 data before", 8'h80);
    wr(2'd0, 8'h03);
    bus_start();
    expect_event("R10 restart code", 8'hA0);
    wr(2'd0, 8'h03);
    xfer({OWN, 1'b0}, ack, seen);
    chk("R10 readdress ack", ack, 1'b1);
    expect_event("R10 readdress status", 8'h60);
    wr(2'd0, 8'h03);
    bus_stop();
    expect_event("R10 final stop", 8'hA0);
    wr(2'd0, 8'h03);

    // R11 read direction
    bus_start();
    xfer({OWN, 1'b1}, ack, seen);
    chk("R11 ack", ack, 1'b1);
    expect_event("R11 status", 8'hA8);
    wr(2'd0, 8'h03);
    chk("R11 released", scl_oe, 1'b0);
    xfer(8'hFF, ack, seen);
    chk("R11 bus byte", seen, 8'hFF);
    chk("R11 no irq", irq, 1'b0);
    bus_stop();
    chk("R11 stop no irq", irq, 1'b0);

    done = 1;
    report();
  end

endmodule